// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Target (256 x 16)

This block models a serial EEPROM target that holds 256 words of 16 bits and is driven over three wires: a chip select, a serial clock and a serial data input, with one serial data output. All three inputs are oversampled by the system clock through two-flop synchronisers. The block acts only on detected rising edges of the serial clock. A command opens with a start bit, which is the first `1` seen after chip select rises. A 2-bit opcode and an 8-bit address follow, most significant bit first. Write commands then carry 16 data bits.

Reads put a single `0` placeholder bit on the output and then stream words, MSB first. The address advances after every word and wraps from 255 to 0. Writes, erases and their whole-array forms are held until chip select falls. Each then starts a self-timed programming cycle whose length is a clock-count parameter. While that cycle runs, the output reports ready/busy status whenever chip select is high. Writes are refused until an enable command has been received. That protection is active after reset.

Top module: `mw_eeprom_slave`

## Requirements
- R1: After reset the array reads 16'hFFFF everywhere, no programming cycle runs, and the block is write-protected.
- R2: While chip select is high, serial-clock rises that sample a 0 before the start bit are ignored.
- R3: Opcode 10 is READ. The rise that takes the last address bit drives DO to 0. Each following rise drives the next data bit, D15 first, and DO changes only after a serial-clock rise.
- R4: A READ kept clocked streams the following addresses without another placeholder bit, wrapping from address 255 to address 0.
- R5: Before any enable command, a WRITE (opcode 01) leaves memory unchanged and starts no busy period.
- R6: Opcode 00 with address bits [7:6] = 11 enables writing. A later WRITE to an address with 16 data bits, D15 first, stores that word.
- R7: Programming starts when chip select falls after a complete command. For PROG_CYCLES clocks, a raised chip select shows DO = 0 and start bits are ignored. After that, DO = 1.
- R8: Opcode 11 (ERASE) sets the addressed word to 16'hFFFF.
- R9: Opcode 00 with address bits [7:6] = 01 takes 16 data bits and writes them into every word.
- R10: Opcode 00 with address bits [7:6] = 10 sets every word to 16'hFFFF.
- R11: Opcode 00 with address bits [7:6] = 00 disables writing again, after which WRITE has no effect.
- R12: If chip select falls before a command is complete, memory is unchanged and no busy period starts.
- R13: The DO output enable follows the synchronised chip select, and DO reads 0 whenever the enable is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_i | input | 1 | Chip select, active high, asynchronous to clk |
| sk_i | input | 1 | Serial clock, asynchronous to clk |
| di_i | input | 1 | Serial data in: start bit, opcode, address and data |
| do_o | output | 1 | Serial data out: read data or ready/busy status |
| do_oe_o | output | 1 | Output enable for do_o; low means high impedance |

## Verification
The assertions assume that each high and low phase of the serial clock spans at least two system clocks, so every rise is seen exactly once. They also assume that DI and chip select change only while the serial clock is low, so the synchronised DI is stable at each detected rise. The stimulus holds every serial-clock phase for four system clocks and changes DI and chip select only in the low phase. It samples DO at the end of each high phase, well after the output register has updated.

// File: rtl/mw_pkg.sv
// Shared types and command encodings for the three-wire EEPROM target.
// Assumes: opcodes and extended-command codes are fixed by the serial protocol.
package mw_pkg;

    typedef enum logic [2:0] {
        ST_WAIT = 3'd0,   // chip select high, waiting for a start bit
        ST_OPC  = 3'd1,   // shifting in the 2-bit opcode
        ST_ADDR = 3'd2,   // shifting in the address field
        ST_DATA = 3'd3,   // shifting in write data
        ST_READ = 3'd4,   // streaming read data out
        ST_DONE = 3'd5    // command complete, waiting for chip select to fall
    } mw_state_e;

    typedef enum logic [1:0] {
        PG_WRITE = 2'd0,
        PG_ERASE = 2'd1,
        PG_WRALL = 2'd2,
        PG_ERALL = 2'd3
    } mw_prog_e;

    localparam logic [1:0] OPC_EXT   = 2'b00;
    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_ERASE = 2'b11;

    localparam logic [1:0] EXT_WDIS  = 2'b00;
    localparam logic [1:0] EXT_WRALL = 2'b01;
    localparam logic [1:0] EXT_ERALL = 2'b10;
    localparam logic [1:0] EXT_WEN   = 2'b11;

endpackage

// File: rtl/mw_sync.sv
// Two-flop synchroniser for a bundle of asynchronous single-bit inputs.
// Assumes: each input is a level that stays stable for several clk periods.
module mw_sync #(
    parameter int N_SIG = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SIG-1:0] async_i,
    output logic [N_SIG-1:0] sync_o
);

    logic [N_SIG-1:0] meta_q;
    logic [N_SIG-1:0] sync_q;

    // Two register stages per input bit.
    for (genvar i = 0; i < N_SIG; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q[i] <= 1'b0;
                sync_q[i] <= 1'b0;
            end else begin
                meta_q[i] <= async_i[i];
                sync_q[i] <= meta_q[i];
            end
        end
    end

    assign sync_o = sync_q;

endmodule

// File: rtl/mw_store.sv
// Word array with whole-array write/erase and the self-timed programming timer.
// Assumes: go_i is a one-cycle pulse, raised only while not busy and only when writes are enabled.
module mw_store
    import mw_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int ADDR_W      = 8,
    parameter int PROG_CYCLES = 5000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  mw_prog_e          op_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [WORD_W-1:0] data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [WORD_W-1:0] rd_data_o,
    output logic              busy_o
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int TMR_W = $clog2(PROG_CYCLES + 1);

    logic              op_all;
    logic              op_erase;
    logic [WORD_W-1:0] wr_val;
    logic [WORD_W-1:0] rd_vec [DEPTH];
    logic [TMR_W-1:0]  tmr_q;

    assign op_all   = (op_i == PG_WRALL) || (op_i == PG_ERALL);
    assign op_erase = (op_i == PG_ERASE) || (op_i == PG_ERALL);
    assign wr_val   = op_erase ? {WORD_W{1'b1}} : data_i;

    // One storage word per address; an erase and the new value land in the same cycle.
    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        logic [WORD_W-1:0] word_q;
        logic              hit;
        assign hit = go_i && (op_all || (addr_i == ADDR_W'(i)));
        // Update this word on a launch that targets it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= {WORD_W{1'b1}};
            end else if (hit) begin
                word_q <= wr_val;
            end
        end
        assign rd_vec[i] = word_q;
    end

    assign rd_data_o = rd_vec[rd_addr_i];

    // Programming timer: loaded on launch, counts down to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else if (go_i) begin
            tmr_q <= TMR_W'(PROG_CYCLES);
        end else if (tmr_q != '0) begin
            tmr_q <= tmr_q - 1'b1;
        end
    end

    assign busy_o = (tmr_q != '0);

    // R7
    no_launch_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go_i |-> !busy_o);

    // R7
    busy_after_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go_i |=> busy_o);

endmodule

// File: rtl/mw_ctrl.sv
// Serial command engine: start-bit hunt, opcode/address/data shifting, read streaming,
// write-enable latch and launch of programming on the falling edge of chip select.
// Assumes: synchronised inputs; SK high and low phases each span at least two clk periods.
module mw_ctrl
    import mw_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              sk_s,
    input  logic              di_s,
    input  logic              busy_i,
    input  logic [WORD_W-1:0] rd_data_i,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              go_o,
    output mw_prog_e          op_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [WORD_W-1:0] data_o,
    output logic              do_o
);

    localparam int MAX_W = (WORD_W > ADDR_W) ? WORD_W : ADDR_W;
    localparam int CNT_W = $clog2(MAX_W) + 1;

    mw_state_e         st_q;
    logic              sk_d_q;
    logic              cs_d_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [1:0]        opc_q;
    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] data_q;
    logic [WORD_W-1:0] sh_q;
    logic [ADDR_W-1:0] rptr_q;
    logic              pend_q;
    mw_prog_e          pend_op_q;
    logic              wen_q;
    logic              do_q;

    logic              sk_rise;
    logic              cs_fall;
    logic [ADDR_W-1:0] addr_nx;

    assign sk_rise = sk_s && !sk_d_q;
    assign cs_fall = cs_d_q && !cs_s;
    assign addr_nx = {addr_q[ADDR_W-2:0], di_s};

    // The array read port looks at the address being completed, then at the stream pointer.
    assign rd_addr_o = (st_q == ST_ADDR) ? addr_nx : rptr_q;

    // Command sequencing on every detected SK rise while chip select is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_WAIT;
            sk_d_q    <= 1'b0;
            cs_d_q    <= 1'b0;
            cnt_q     <= '0;
            opc_q     <= '0;
            addr_q    <= '0;
            data_q    <= '0;
            sh_q      <= '0;
            rptr_q    <= '0;
            pend_q    <= 1'b0;
            pend_op_q <= PG_WRITE;
            wen_q     <= 1'b0;
            do_q      <= 1'b0;
        end else begin
            sk_d_q <= sk_s;
            cs_d_q <= cs_s;
            if (!cs_s) begin
                st_q   <= ST_WAIT;
                pend_q <= 1'b0;
            end else if (sk_rise) begin
                case (st_q)
                    ST_WAIT: begin
                        if (di_s && !busy_i) begin
                            st_q  <= ST_OPC;
                            cnt_q <= '0;
                        end
                    end
                    ST_OPC: begin
                        opc_q <= {opc_q[0], di_s};
                        if (cnt_q == CNT_W'(1)) begin
                            st_q  <= ST_ADDR;
                            cnt_q <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    ST_ADDR: begin
                        addr_q <= addr_nx;
                        if (cnt_q == CNT_W'(ADDR_W - 1)) begin
                            cnt_q <= '0;
                            case (opc_q)
                                OPC_READ: begin
                                    st_q   <= ST_READ;
                                    sh_q   <= rd_data_i;
                                    rptr_q <= addr_nx + 1'b1;
                                    do_q   <= 1'b0;
                                end
                                OPC_WRITE: begin
                                    st_q      <= ST_DATA;
                                    pend_op_q <= PG_WRITE;
                                end
                                OPC_ERASE: begin
                                    st_q      <= ST_DONE;
                                    pend_q    <= 1'b1;
                                    pend_op_q <= PG_ERASE;
                                end
                                default: begin
                                    st_q <= ST_DONE;
                                    case (addr_nx[ADDR_W-1 -: 2])
                                        EXT_WEN:   wen_q <= 1'b1;
                                        EXT_WDIS:  wen_q <= 1'b0;
                                        EXT_WRALL: begin
                                            st_q      <= ST_DATA;
                                            pend_op_q <= PG_WRALL;
                                        end
                                        default: begin
                                            pend_q    <= 1'b1;
                                            pend_op_q <= PG_ERALL;
                                        end
                                    endcase
                                end
                            endcase
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        data_q <= {data_q[WORD_W-2:0], di_s};
                        if (cnt_q == CNT_W'(WORD_W - 1)) begin
                            st_q   <= ST_DONE;
                            pend_q <= 1'b1;
                            cnt_q  <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    ST_READ: begin
                        do_q <= sh_q[WORD_W-1];
                        if (cnt_q == CNT_W'(WORD_W - 1)) begin
                            sh_q   <= rd_data_i;
                            rptr_q <= rptr_q + 1'b1;
                            cnt_q  <= '0;
                        end else begin
                            sh_q  <= {sh_q[WORD_W-2:0], 1'b0};
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign go_o   = cs_fall && (st_q == ST_DONE) && pend_q && wen_q;
    assign op_o   = pend_op_q;
    assign addr_o = addr_q;
    assign data_o = data_q;
    assign do_o   = (st_q == ST_WAIT) ? !busy_i : do_q;

    // R3
    do_moves_on_sk_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sk_rise |=> $stable(do_q));

    // R12
    cs_low_aborts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_s |=> (st_q == ST_WAIT) && !pend_q);

endmodule

// File: rtl/mw_eeprom_slave.sv
// Top of the three-wire EEPROM target: synchroniser, command engine and storage.
// Assumes: cs_i, sk_i and di_i are asynchronous and much slower than clk.
module mw_eeprom_slave
    import mw_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int ADDR_W      = 8,
    parameter int PROG_CYCLES = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_i,
    input  logic sk_i,
    input  logic di_i,
    output logic do_o,
    output logic do_oe_o
);

    logic [2:0]        pins_s;
    logic              cs_s;
    logic              sk_s;
    logic              di_s;
    logic              busy;
    logic              go;
    mw_prog_e          op;
    logic [ADDR_W-1:0] addr;
    logic [WORD_W-1:0] data;
    logic [ADDR_W-1:0] rd_addr;
    logic [WORD_W-1:0] rd_data;
    logic              ctrl_do;

    mw_sync #(.N_SIG(3)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({cs_i, sk_i, di_i}),
        .sync_o  (pins_s)
    );

    assign cs_s = pins_s[2];
    assign sk_s = pins_s[1];
    assign di_s = pins_s[0];

    mw_ctrl #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_s      (cs_s),
        .sk_s      (sk_s),
        .di_s      (di_s),
        .busy_i    (busy),
        .rd_data_i (rd_data),
        .rd_addr_o (rd_addr),
        .go_o      (go),
        .op_o      (op),
        .addr_o    (addr),
        .data_o    (data),
        .do_o      (ctrl_do)
    );

    mw_store #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .PROG_CYCLES(PROG_CYCLES)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .go_i      (go),
        .op_i      (op),
        .addr_i    (addr),
        .data_i    (data),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data),
        .busy_o    (busy)
    );

    assign do_oe_o = cs_s;
    assign do_o    = cs_s && ctrl_do;

    // R7
    busy_starts_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !do_oe_o);

endmodule

// File: tb/mw_eeprom_slave_tb.sv
// Bench for the three-wire EEPROM target: behavioural memory model plus per-clock pin checks.
module mw_eeprom_slave_tb_top;

    localparam int PROG = 600;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0;
    logic sk = 1'b0;
    logic di = 1'b0;
    logic do_w;
    logic oe_w;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [15:0] ref_mem [256];
    bit          ref_wen;
    logic        cs_h1, cs_h2;

    always #10 clk = ~clk;

    mw_eeprom_slave #(.WORD_W(16), .ADDR_W(8), .PROG_CYCLES(PROG)) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_i    (cs),
        .sk_i    (sk),
        .di_i    (di),
        .do_o    (do_w),
        .do_oe_o (oe_w)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Expected chip-select delay through the input synchroniser.
    always @(posedge clk) begin
        if (!rst_n) begin
            cs_h1 <= 1'b0;
            cs_h2 <= 1'b0;
        end else begin
            cs_h1 <= cs;
            cs_h2 <= cs_h1;
        end
    end

    // R13: output enable and quiet DO compared on every clock.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(oe_w === cs_h2, "R13 oe", {31'd0, oe_w}, {31'd0, cs_h2});
            if (!oe_w) chk(do_w === 1'b0, "R13 do", {31'd0, do_w}, 32'd0);
        end
    end

    task automatic sk_bit(input logic b, output logic d);
        @(negedge clk);
        di = b;
        repeat (4) @(negedge clk);
        sk = 1'b1;
        repeat (4) @(negedge clk);
        d = do_w;
        sk = 1'b0;
    endtask

    task automatic send(input logic [31:0] v, input int n);
        logic d;
        for (int i = n - 1; i >= 0; i--) sk_bit(v[i], d);
    endtask

    task automatic cs_up();
        @(negedge clk);
        cs = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic cs_down();
        @(negedge clk);
        cs = 1'b0;
        di = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic wait_prog();
        repeat (PROG + 20) @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] a, input int nw, input int lead, input string req);
        logic d;
        cs_up();
        for (int i = 0; i < lead; i++) sk_bit(1'b0, d);
        send({29'd0, 3'b110}, 3);
        send({24'd0, a[7:1], 1'b0} >> 1, 7);
        sk_bit(a[0], d);
        chk(d === 1'b0, "R3 dummy bit", {31'd0, d}, 32'd0);
        for (int w = 0; w < nw; w++) begin
            logic [7:0] aw;
            aw = a + 8'(w);
            for (int b = 15; b >= 0; b--) begin
                sk_bit(1'b0, d);
                chk(d === ref_mem[aw][b], req, {31'd0, d}, {31'd0, ref_mem[aw][b]});
            end
        end
        cs_down();
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] v);
        cs_up();
        send({29'd0, 3'b101}, 3);
        send({24'd0, a}, 8);
        send({16'd0, v}, 16);
        cs_down();
        if (ref_wen) begin
            ref_mem[a] = v;
            wait_prog();
        end
    endtask

    task automatic ext(input logic [1:0] code, input logic [15:0] v);
        cs_up();
        send({29'd0, 3'b100}, 3);
        send({24'd0, code, 6'b000000}, 8);
        if (code == 2'b01) send({16'd0, v}, 16);
        cs_down();
        if (code == 2'b11) ref_wen = 1'b1;
        if (code == 2'b00) ref_wen = 1'b0;
        if (ref_wen && (code == 2'b01 || code == 2'b10)) begin
            for (int i = 0; i < 256; i++) ref_mem[i] = (code == 2'b01) ? v : 16'hFFFF;
            wait_prog();
        end
    endtask

    task automatic ready_is(input logic exp, input string req);
        cs_up();
        repeat (4) @(negedge clk);
        chk(do_w === exp, req, {31'd0, do_w}, {31'd0, exp});
        cs_down();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) ref_mem[i] = 16'hFFFF;
        ref_wen = 1'b0;
        repeat (5) @(negedge clk);
        chk(oe_w === 1'b0 && do_w === 1'b0, "R1 reset pins", {30'd0, oe_w, do_w}, 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1: erased after reset, not busy
        ready_is(1'b1, "R1 ready after reset");
        rd(8'h00, 1, 0, "R1 erased word");

        // R5: write refused while protected
        wr(8'h12, 16'hA5C3);
        ready_is(1'b1, "R5 no busy when protected");
        rd(8'h12, 1, 0, "R5 memory unchanged");

        // R6: enable then write
        ext(2'b11, 16'h0000);
        wr(8'h12, 16'hA5C3);
        rd(8'h12, 1, 0, "R6 write stored");

        // R2: leading zeros before the start bit
        rd(8'h12, 1, 3, "R2 leading zeros ignored");

        // R7: busy status and start bits ignored while busy
        cs_up();
        send({29'd0, 3'b101}, 3);
        send({24'd0, 8'h30}, 8);
        send({16'd0, 16'h1234}, 16);
        cs_down();
        ref_mem[8'h30] = 16'h1234;
        cs_up();
        repeat (4) @(negedge clk);
        chk(do_w === 1'b0, "R7 busy shows 0", {31'd0, do_w}, 32'd0);
        send({29'd0, 3'b101}, 3);
        send({24'd0, 8'h31}, 8);
        send({16'd0, 16'hBEEF}, 16);
        chk(do_w === 1'b0, "R7 still busy", {31'd0, do_w}, 32'd0);
        cs_down();
        wait_prog();
        ready_is(1'b1, "R7 ready after cycle");
        rd(8'h30, 2, 0, "R7 write kept, busy command ignored");

        // R4: auto-increment with wrap
        wr(8'hFF, 16'h0F0F);
        wr(8'h00, 16'h8001);
        rd(8'hFE, 4, 0, "R4 stream wraps");

        // R8: erase one word
        cs_up();
        send({29'd0, 3'b111}, 3);
        send({24'd0, 8'h12}, 8);
        cs_down();
        ref_mem[8'h12] = 16'hFFFF;
        wait_prog();
        rd(8'h11, 3, 0, "R8 erase word");

        // R12: abort mid-data
        cs_up();
        send({29'd0, 3'b101}, 3);
        send({24'd0, 8'h40}, 8);
        send({24'd0, 8'h00}, 8);
        cs_down();
        ready_is(1'b1, "R12 no busy after abort");
        rd(8'h40, 1, 0, "R12 memory unchanged");

        // R9: write all
        ext(2'b01, 16'h5A5A);
        rd(8'h77, 1, 0, "R9 write all");
        rd(8'hFF, 2, 0, "R9 write all ends");

        // R10: erase all
        ext(2'b10, 16'h0000);
        rd(8'h13, 2, 0, "R10 erase all");

        // R11: disable then write refused
        ext(2'b00, 16'h0000);
        wr(8'h20, 16'h0000);
        ready_is(1'b1, "R11 no busy when disabled");
        rd(8'h20, 1, 0, "R11 write refused");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule